// File: doc/BRIEF.md
# Serial Port Register and Interrupt Identification Block

This block is the register side of a 16550-compatible serial controller. A host reaches eight byte-wide registers through a 3-bit offset, with separate read and write enables. It holds the interrupt-enable bits, the line-control byte, the modem-control bits, a scratch byte and the 16-bit baud divisor. It builds the line-status byte and reports the single highest-priority interrupt cause in an identification byte. Reading that byte has side effects, and so does reading the line-status byte.

Neighbouring blocks supply the receive FIFO occupancy and its head byte, an overrun pulse and a modem-change-pending level. The block gives back strobes that pop the receive FIFO, push a transmit byte, flush the receive FIFO and acknowledge a modem status read. It also drives the divisor to the baud generator and a level interrupt to the host. The transmitter is treated as always ready. Read data is combinational from the current state, and all side effects of an access take effect at the clock edge that ends it.

Top module: `sercom_regblk`

## Requirements
- R1: When several causes are enabled at once, the identification byte (offset 2) reports only the most urgent one, in its low nibble. The codes are: overrun with IER bit 2 gives 0x6; receive count above zero with IER bit 0 gives 0x4; transmit-empty pending with IER bit 1 gives 0x2; modem change pending with IER bit 3 gives 0x0. They rank in that order, overrun first.
- R2: `irqOut` is high exactly when at least one enabled cause exists. With none, the identification byte low nibble is 0x1.
- R3: A write to the interrupt-enable register (offset 1, DLAB clear) stores only data bits 3:0. Bits 7:4 read back as zero.
- R4: A write to offset 0 with DLAB clear pulses `txPush` with `txData` equal to the written byte, and it sets the transmit-empty pending flag. An identification read that reports code 0x2 clears the flag. An identification read that reports any other code leaves it set.
- R5: A write to offset 2 stores data bit 0 as FIFO mode. In FIFO mode the identification byte has bits 7:6 set. `rxFlush` pulses during the write when bit 0 changes the mode, or when bit 0 and bit 1 are both set.
- R6: The line-status byte (offset 5) always has bit 6 and bit 5 set. Bit 0 is set when the receive count is non-zero, and bit 1 is the overrun flag.
- R7: An `rxOverrun` pulse sets the overrun flag, which stays set. A line-status read clears it, except that a pulse in the same cycle as the read wins.
- R8: LCR bit 7 is DLAB. While it is set, offsets 0 and 1 read and write the divisor low and high bytes, which appear on `divisor`. While it is clear, a read of offset 0 returns `rxData` and pulses `rxPop`. A read of offset 0 with DLAB set does not pulse `rxPop`.
- R9: Reset loads the divisor with 1843200/9600/16 = 12. Every other stored register resets to zero.
- R10: Offset 7 is a scratch byte that reads back what was written, with no side effects.
- R11: Offset 3 holds all 8 written bits. Offset 4 keeps data bits 4:0. A read of offset 6 returns `modemChg` in bit 0, with the other bits zero, and pulses `mdmAck`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register offset |
| busWrEn | input | 1 | Write enable for this cycle |
| busRdEn | input | 1 | Read enable for this cycle |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data (combinational) |
| rxCount | input | CNT_W | Receive FIFO occupancy |
| rxData | input | 8 | Receive FIFO head byte |
| rxOverrun | input | 1 | Overrun event pulse |
| modemChg | input | 1 | Modem change pending level |
| irqOut | output | 1 | Level interrupt to host |
| rxPop | output | 1 | Pop strobe to receive FIFO |
| txPush | output | 1 | Transmit byte strobe |
| txData | output | 8 | Transmit byte |
| rxFlush | output | 1 | Receive FIFO flush strobe |
| mdmAck | output | 1 | Modem status read strobe |
| divisor | output | 16 | Baud divisor |

## Verification
The assertions assume that a cycle never carries both a read enable and a write enable. Such a cycle is treated as a write only, and no read strobe fires. They also assume that `rxOverrun` is a single-cycle pulse. The stimulus drives each access in its own cycle from a task that raises only one enable. It pulses the overrun input for exactly one cycle, including once on top of a line-status read, which checks that the set-wins rule holds.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IEN  = 3'd1;
  localparam logic [2:0] OFS_IID  = 3'd2;
  localparam logic [2:0] OFS_LCTL = 3'd3;
  localparam logic [2:0] OFS_MCTL = 3'd4;
  localparam logic [2:0] OFS_LSTA = 3'd5;
  localparam logic [2:0] OFS_MSTA = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  typedef enum logic [3:0] {
    IID_LINE = 4'h6,
    IID_RX   = 4'h4,
    IID_TX   = 4'h2,
    IID_MDM  = 4'h0,
    IID_NONE = 4'h1
  } iidCode_e;

  typedef struct packed {
    logic wrThr;
    logic wrIen;
    logic wrDivLo;
    logic wrDivHi;
    logic wrFifo;
    logic wrLctl;
    logic wrMctl;
    logic wrScr;
    logic rdRx;
    logic rdIid;
    logic rdLsta;
    logic rdMsta;
  } regStb_t;
endpackage

// File: rtl/sercom_ctl.sv
module sercom_ctl
  import sercom_pkg::*;
(
  input  logic [2:0] busAddr,
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic       dlab,
  output regStb_t    stb
);
  logic rdOnly;
  assign rdOnly = busRdEn && !busWrEn;

  always_comb begin
    stb = '0;
    if (busWrEn) begin
      unique case (busAddr)
        OFS_DATA: if (dlab) stb.wrDivLo = 1'b1; else stb.wrThr = 1'b1;
        OFS_IEN:  if (dlab) stb.wrDivHi = 1'b1; else stb.wrIen = 1'b1;
        OFS_IID:  stb.wrFifo = 1'b1;
        OFS_LCTL: stb.wrLctl = 1'b1;
        OFS_MCTL: stb.wrMctl = 1'b1;
        OFS_SCR:  stb.wrScr  = 1'b1;
        default:  ;
      endcase
    end
    if (rdOnly) begin
      unique case (busAddr)
        OFS_DATA: stb.rdRx   = !dlab;
        OFS_IID:  stb.rdIid  = 1'b1;
        OFS_LSTA: stb.rdLsta = 1'b1;
        OFS_MSTA: stb.rdMsta = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/sercom_dp.sv
module sercom_dp
  import sercom_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter logic [15:0] DIV_INIT = 16'd12
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStb_t          stb,
  input  logic [2:0]       busAddr,
  input  logic [7:0]       busWrData,
  output logic [7:0]       busRdData,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [7:0]       rxData,
  input  logic             rxOverrun,
  input  logic             modemChg,
  output logic             irqOut,
  output logic             rxFlush,
  output logic             dlab,
  output logic             fifoEn,
  output logic             oeFlag,
  output logic             txPend,
  output logic [15:0]      divisor
);
  logic [3:0] ienQ;
  logic [7:0] lctlQ;
  logic [4:0] mctlQ;
  logic [7:0] scrQ;
  logic [7:0] divLoQ, divHiQ;
  logic       fifoEnQ, txPendQ, oeQ;
  logic       rxAvail;
  iidCode_e   iid;
  logic [7:0] iidByte, lstaByte;

  assign rxAvail = (rxCount != '0);

  always_comb begin
    if (oeQ && ienQ[2])            iid = IID_LINE;
    else if (rxAvail && ienQ[0])   iid = IID_RX;
    else if (txPendQ && ienQ[1])   iid = IID_TX;
    else if (modemChg && ienQ[3])  iid = IID_MDM;
    else                           iid = IID_NONE;
  end

  assign irqOut   = (iid != IID_NONE);
  assign iidByte  = {{2{fifoEnQ}}, 2'b00, iid};
  assign lstaByte = {1'b0, 2'b11, 3'b000, oeQ, rxAvail};
  assign rxFlush  = stb.wrFifo &&
                    ((busWrData[0] != fifoEnQ) || (busWrData[0] && busWrData[1]));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienQ    <= '0;
      lctlQ   <= '0;
      mctlQ   <= '0;
      scrQ    <= '0;
      divLoQ  <= DIV_INIT[7:0];
      divHiQ  <= DIV_INIT[15:8];
      fifoEnQ <= 1'b0;
      txPendQ <= 1'b0;
      oeQ     <= 1'b0;
    end else begin
      if (stb.wrIen)   ienQ    <= busWrData[3:0];
      if (stb.wrLctl)  lctlQ   <= busWrData;
      if (stb.wrMctl)  mctlQ   <= busWrData[4:0];
      if (stb.wrScr)   scrQ    <= busWrData;
      if (stb.wrDivLo) divLoQ  <= busWrData;
      if (stb.wrDivHi) divHiQ  <= busWrData;
      if (stb.wrFifo)  fifoEnQ <= busWrData[0];
      if (stb.wrThr)
        txPendQ <= 1'b1;
      else if (stb.rdIid && iid == IID_TX)
        txPendQ <= 1'b0;
      if (rxOverrun)
        oeQ <= 1'b1;
      else if (stb.rdLsta)
        oeQ <= 1'b0;
    end
  end

  always_comb begin
    unique case (busAddr)
      OFS_DATA: busRdData = lctlQ[7] ? divLoQ : rxData;
      OFS_IEN:  busRdData = lctlQ[7] ? divHiQ : {4'b0000, ienQ};
      OFS_IID:  busRdData = iidByte;
      OFS_LCTL: busRdData = lctlQ;
      OFS_MCTL: busRdData = {3'b000, mctlQ};
      OFS_LSTA: busRdData = lstaByte;
      OFS_MSTA: busRdData = {7'b0, modemChg};
      default:  busRdData = scrQ;
    endcase
  end

  assign dlab    = lctlQ[7];
  assign fifoEn  = fifoEnQ;
  assign oeFlag  = oeQ;
  assign txPend  = txPendQ;
  assign divisor = {divHiQ, divLoQ};
endmodule

// File: rtl/sercom_regblk.sv
module sercom_regblk
  import sercom_pkg::*;
#(
  parameter int REF_CLK_HZ = 1843200,
  parameter int BAUD       = 9600,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       busAddr,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [7:0]       busWrData,
  output logic [7:0]       busRdData,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [7:0]       rxData,
  input  logic             rxOverrun,
  input  logic             modemChg,
  output logic             irqOut,
  output logic             rxPop,
  output logic             txPush,
  output logic [7:0]       txData,
  output logic             rxFlush,
  output logic             mdmAck,
  output logic [15:0]      divisor
);
  localparam int DIV_CALC = REF_CLK_HZ / BAUD / 16;
  localparam logic [15:0] DIV_INIT = DIV_CALC[15:0];

  regStb_t stb;
  logic dlab, fifoEn, oeFlag, txPend;

  sercom_ctl u_ctl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .dlab(dlab), .stb(stb)
  );

  sercom_dp #(.CNT_W(CNT_W), .DIV_INIT(DIV_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .rxCount(rxCount), .rxData(rxData), .rxOverrun(rxOverrun),
    .modemChg(modemChg), .irqOut(irqOut), .rxFlush(rxFlush),
    .dlab(dlab), .fifoEn(fifoEn), .oeFlag(oeFlag), .txPend(txPend),
    .divisor(divisor)
  );

  assign rxPop  = stb.rdRx;
  assign txPush = stb.wrThr;
  assign txData = busWrData;
  assign mdmAck = stb.rdMsta;
endmodule

// File: rtl/sercom_chk.sv
module sercom_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       busAddr,
  input logic             busWrEn,
  input logic             busRdEn,
  input logic [7:0]       busRdData,
  input logic [CNT_W-1:0] rxCount,
  input logic             rxOverrun,
  input logic             irqOut,
  input logic             rxPop,
  input logic             dlab,
  input logic             fifoEn,
  input logic             oeFlag,
  input logic             txPend
);
  logic rdCyc;
  assign rdCyc = busRdEn && !busWrEn;

  a_r2_none_code: assert property (@(posedge clk) disable iff (!rstN)
    (rdCyc && busAddr == 3'd2 && !irqOut) |-> busRdData[3:0] == 4'h1);

  a_r2_some_code: assert property (@(posedge clk) disable iff (!rstN)
    (rdCyc && busAddr == 3'd2 && irqOut) |-> !busRdData[0]);

  a_r3_ien_upper: assert property (@(posedge clk) disable iff (!rstN)
    (rdCyc && busAddr == 3'd1 && !dlab) |-> busRdData[7:4] == 4'h0);

  a_r4_tx_set: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 3'd0 && !dlab) |=> txPend);

  a_r5_fifo_tag: assert property (@(posedge clk) disable iff (!rstN)
    (rdCyc && busAddr == 3'd2 && fifoEn) |-> busRdData[7:6] == 2'b11);

  a_r6_lsta_bits: assert property (@(posedge clk) disable iff (!rstN)
    (rdCyc && busAddr == 3'd5) |->
      (busRdData[6:5] == 2'b11 && busRdData[0] == (rxCount != '0)));

  a_r7_oe_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdCyc && busAddr == 3'd5 && !rxOverrun) |=> !oeFlag);

  a_r7_oe_set: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |=> oeFlag);

  a_r8_pop_only: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> (rdCyc && busAddr == 3'd0 && !dlab));
endmodule

bind sercom_regblk sercom_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_sercom_regblk.sv
module test_sercom_regblk;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [CNT_W-1:0] rxCount = '0;
  logic [7:0] rxData = '0;
  logic rxOverrun = 1'b0, modemChg = 1'b0;
  logic irqOut, rxPop, txPush, rxFlush, mdmAck;
  logic [7:0] txData;
  logic [15:0] divisor;

  always #4 clk = ~clk;

  sercom_regblk #(.CNT_W(CNT_W)) i_sercom_regblk (.*);

  int nTests = 0, nFail = 0;
  logic lastIrq, lastPop, lastAck, lastPush, lastFlush;
  logic [7:0] lastTxd, rv;

  typedef struct packed {
    logic       rd;
    logic [2:0] addr;
    logic [7:0] data;
    logic       irq;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'd1, 8'h00, 1'b0, 8'd3},  // R3 enable reset value
    '{1'b1, 3'd2, 8'h01, 1'b0, 8'd2},  // R2 nothing pending
    '{1'b1, 3'd5, 8'h60, 1'b0, 8'd6},  // R6 idle line status
    '{1'b0, 3'd3, 8'h80, 1'b0, 8'd8},
    '{1'b1, 3'd0, 8'h0C, 1'b0, 8'd9},  // R9 divisor low
    '{1'b1, 3'd1, 8'h00, 1'b0, 8'd9},  // R9 divisor high
    '{1'b0, 3'd0, 8'h34, 1'b0, 8'd8},
    '{1'b0, 3'd1, 8'h12, 1'b0, 8'd8},
    '{1'b1, 3'd0, 8'h34, 1'b0, 8'd8},  // R8
    '{1'b1, 3'd1, 8'h12, 1'b0, 8'd8},
    '{1'b0, 3'd3, 8'h03, 1'b0, 8'd11},
    '{1'b1, 3'd3, 8'h03, 1'b0, 8'd11}, // R11
    '{1'b0, 3'd1, 8'hFF, 1'b0, 8'd3},
    '{1'b1, 3'd1, 8'h0F, 1'b0, 8'd3},
    '{1'b0, 3'd0, 8'h55, 1'b0, 8'd4},
    '{1'b1, 3'd2, 8'h02, 1'b1, 8'd4},  // R4 cause then cleared
    '{1'b1, 3'd2, 8'h01, 1'b0, 8'd4},
    '{1'b0, 3'd7, 8'hA5, 1'b0, 8'd10},
    '{1'b1, 3'd7, 8'hA5, 1'b0, 8'd10}, // R10
    '{1'b0, 3'd4, 8'hFF, 1'b0, 8'd11},
    '{1'b1, 3'd4, 8'h1F, 1'b0, 8'd11},
    '{1'b1, 3'd6, 8'h00, 1'b0, 8'd11}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    #1;
    lastPush = txPush; lastTxd = txData; lastFlush = rxFlush;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1;
    d = busRdData; lastIrq = irqOut; lastPop = rxPop; lastAck = mdmAck;
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R9 reset divisor", divisor, 16'h000C);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].rd) begin
        doRead(TBL[i].addr, rv);
        check($sformatf("R%0d table[%0d] data", TBL[i].req, i), {8'h0, rv}, {8'h0, TBL[i].data});
        check($sformatf("R%0d table[%0d] irq", TBL[i].req, i), {15'h0, lastIrq}, {15'h0, TBL[i].irq});
      end else begin
        doWrite(TBL[i].addr, TBL[i].data);
      end
    end
    check("R8 divisor output", divisor, 16'h1234);

    // R1 priority ladder, all enables on
    modemChg = 1'b1;
    doRead(3'd2, rv); check("R1 modem code", {8'h0, rv}, 16'h0000);
    check("R2 irq with modem", {15'h0, lastIrq}, 16'h1);
    doRead(3'd6, rv); check("R11 modem read", {8'h0, rv}, 16'h0001);
    check("R11 mdmAck", {15'h0, lastAck}, 16'h1);
    doWrite(3'd0, 8'h3C);
    check("R4 txPush", {15'h0, lastPush}, 16'h1);
    check("R4 txData", {8'h0, lastTxd}, 16'h003C);
    doRead(3'd2, rv); check("R1 tx over modem", {8'h0, rv}, 16'h0002);
    doRead(3'd2, rv); check("R4 tx cleared", {8'h0, rv}, 16'h0000);
    rxCount = 5'd3; rxData = 8'h77;
    doRead(3'd2, rv); check("R1 rx over modem", {8'h0, rv}, 16'h0004);
    doRead(3'd5, rv); check("R6 data ready", {8'h0, rv}, 16'h0061);
    doRead(3'd0, rv); check("R8 rx data", {8'h0, rv}, 16'h0077);
    check("R8 rxPop", {15'h0, lastPop}, 16'h1);
    @(negedge clk); rxOverrun = 1'b1;
    @(negedge clk); rxOverrun = 1'b0;
    doRead(3'd2, rv); check("R1 overrun top", {8'h0, rv}, 16'h0006);
    doRead(3'd5, rv); check("R7 overrun seen", {8'h0, rv}, 16'h0063);
    doRead(3'd5, rv); check("R7 overrun cleared", {8'h0, rv}, 16'h0061);

    // R7 set wins over a read in the same cycle
    @(negedge clk); busAddr = 3'd5; busRdEn = 1'b1; rxOverrun = 1'b1;
    @(posedge clk); #1 busRdEn = 1'b0; rxOverrun = 1'b0;
    doRead(3'd5, rv); check("R7 set wins", {8'h0, rv}, 16'h0063);

    // R2 / R4 masking
    doWrite(3'd1, 8'h00);
    doRead(3'd2, rv); check("R2 all masked", {8'h0, rv}, 16'h0001);
    check("R2 irq low", {15'h0, lastIrq}, 16'h0);
    doWrite(3'd0, 8'h11);
    doRead(3'd2, rv);
    rxCount = '0; modemChg = 1'b0;
    doWrite(3'd1, 8'h02);
    doRead(3'd2, rv); check("R4 pending kept", {8'h0, rv}, 16'h0002);
    check("R2 irq tx", {15'h0, lastIrq}, 16'h1);

    // R5 FIFO mode
    doWrite(3'd2, 8'h01); check("R5 flush on enable", {15'h0, lastFlush}, 16'h1);
    doRead(3'd2, rv); check("R5 fifo tag", {8'h0, rv}, 16'h00C1);
    doWrite(3'd2, 8'h01); check("R5 no flush", {15'h0, lastFlush}, 16'h0);
    doWrite(3'd2, 8'h03); check("R5 flush request", {15'h0, lastFlush}, 16'h1);
    doWrite(3'd2, 8'h00); check("R5 flush on disable", {15'h0, lastFlush}, 16'h1);
    doRead(3'd2, rv); check("R5 tag gone", {8'h0, rv}, 16'h0001);

    // R8 no pop while DLAB set
    doWrite(3'd3, 8'h80);
    rxCount = 5'd1;
    doRead(3'd0, rv); check("R8 divisor read", {8'h0, rv}, 16'h0034);
    check("R8 no pop", {15'h0, lastPop}, 16'h0);
    rxCount = '0;

    // R9 reset again
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    check("R9 divisor after reset", divisor, 16'h000C);
    doRead(3'd3, rv); check("R9 lctl zero", {8'h0, rv}, 16'h0000);
    doRead(3'd7, rv); check("R9 scratch zero", {8'h0, rv}, 16'h0000);
    summary();
  end
endmodule